// File: doc/BRIEF.md
# Two-Wire Bus Target Protocol Engine

This block is the serial front end of a small byte-addressed non-volatile store that sits on a two-wire bus. It runs on the system clock and oversamples the bus clock and data lines through synchronizers. It detects start and stop conditions, shifts in a device address byte, a word address byte and data bytes, and acknowledges each accepted byte by pulling the data line low. In read transfers it shifts bytes out over an open-drain enable. Each accepted byte is handed to the neighbouring protection and address-counter logic as a one-cycle event with the byte value beside it. Read data is taken from that logic with a one-cycle take strobe.

A stop that ends a transfer containing at least one data byte opens a self-timed busy window whose length in clocks is a parameter. While the window is open the engine answers no address at all, so a controller can repeat start plus address until an acknowledge comes back. Random reads are a write transfer that carries only the word address, followed by a repeated start and a read-address byte. Sequential reads go on for as long as the controller acknowledges each byte.

Top module: `twi_target_engine`

## Requirements
- R1: After reset the data-line pull-down enable is low, busy is low, and no byte event fires.
- R2: A device address byte is acknowledged (data line held low for the whole ninth clock high phase) only when bits 7:4 equal the DEV_CODE parameter and bits 3:1 equal the three strap inputs. Bit 0 is the direction: 1 = read, 0 = write. Bits are sent MSB first and sampled on the bus clock rising edge.
- R3: A device address byte that does not match is not acknowledged, and every following byte up to the next start is ignored: no acknowledge and no byte event.
- R4: In a write transfer the second byte raises the word-address event and every later byte raises the write-data event. Each carries its byte MSB first on the byte output, and each is acknowledged.
- R5: A stop that ends a transfer with at least one write-data byte raises busy for exactly BUSY_CYCLES clocks. A stop after a transfer with no write-data byte leaves busy low.
- R6: While busy is high a start plus a matching address gets no acknowledge. Once busy has dropped, the same address is acknowledged again.
- R7: A write transfer with only a word address, followed by a repeated start and a matching read-address byte, is acknowledged, and the first byte shifted out is the read-data input value at the take strobe.
- R8: In a read, a new byte is taken and shifted out after every controller acknowledge. After a controller non-acknowledge the engine releases the data line and takes no further byte.
- R9: A start in the middle of any byte aborts the transfer: the partial byte raises no event and the next byte is decoded as a device address.
- R10: The engine changes its data-line drive only after a bus clock falling edge, or on a start or stop, so the line is stable during every clock high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 3 | Strapped device select bits compared with address bits 3:1 |
| rd_data_i | input | 8 | Next read byte from the address counter side |
| sda_oe_o | output | 1 | 1 pulls the data line low (open drain) |
| busy_o | output | 1 | Self-timed write window in progress |
| dev_ev_o | output | 1 | One-cycle pulse: device address accepted |
| dev_rnw_o | output | 1 | Direction of the accepted device address, 1 = read |
| waddr_ev_o | output | 1 | One-cycle pulse: word address byte received |
| wdata_ev_o | output | 1 | One-cycle pulse: write data byte received |
| byte_o | output | 8 | Last received byte, valid with the events |
| rd_take_o | output | 1 | One-cycle pulse: rd_data_i was latched for shifting out |

## Verification
Two functions can meet in one transfer boundary. One is the stop that opens the busy window. The other is a start arriving right behind it, which would normally begin address decoding. The bench provokes this by issuing a start and the matching address immediately after the stop of a byte write. It judges the result by the missing acknowledge and an unchanged device event count, and then by the acknowledge returning once busy has run exactly its parameter length. A second overlap is a repeated start landing on a byte that is still being shifted in, where the abort must win over data capture. The bench judges that by an unchanged write-data event count and a clean acknowledge of the new address.

// File: rtl/twi_pkg.sv
package twi_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_DEV  = 3'd1,
      ST_WADR = 3'd2,
      ST_WDAT = 3'd3,
      ST_RDAT = 3'd4
   } twi_state_t;

   localparam int unsigned BYTE_BITS = 8;
endpackage

// File: rtl/twi_line_sampler.sv
module twi_line_sampler #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_p,
   output logic stop_p
);
   logic [SYNC_STAGES-1:0] scl_chain;
   logic [SYNC_STAGES-1:0] sda_chain;
   logic scl_prev, sda_prev;

   genvar gi;
   generate
      for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_chain[0] <= 1'b1;
                  sda_chain[0] <= 1'b1;
               end else begin
                  scl_chain[0] <= scl_i;
                  sda_chain[0] <= sda_i;
               end
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_chain[gi] <= 1'b1;
                  sda_chain[gi] <= 1'b1;
               end else begin
                  scl_chain[gi] <= scl_chain[gi-1];
                  sda_chain[gi] <= sda_chain[gi-1];
               end
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_prev <= scl_s;
         sda_prev <= sda_s;
      end
   end

   assign scl_s    = scl_chain[SYNC_STAGES-1];
   assign sda_s    = sda_chain[SYNC_STAGES-1];
   assign scl_rise = scl_s & ~scl_prev;
   assign scl_fall = ~scl_s & scl_prev;
   assign start_p  = scl_s & scl_prev & sda_prev & ~sda_s;
   assign stop_p   = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/twi_busy_timer.sv
module twi_busy_timer #(
   parameter int unsigned CYCLES = 250000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   output logic busy
);
   localparam int unsigned CW = $clog2(CYCLES + 1);
   localparam logic [CW-1:0] LOAD = CW'(CYCLES);

   logic [CW-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             remain <= '0;
      else if (go)            remain <= LOAD;
      else if (remain != '0)  remain <= remain - 1'b1;
   end

   assign busy = (remain != '0);
endmodule

// File: rtl/twi_target_engine.sv
module twi_target_engine
   import twi_pkg::*;
#(
   parameter logic [3:0]  DEV_CODE    = 4'b1010,
   parameter int unsigned BUSY_CYCLES = 250000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic [2:0] strap_i,
   input  logic [7:0] rd_data_i,
   output logic       sda_oe_o,
   output logic       busy_o,
   output logic       dev_ev_o,
   output logic       dev_rnw_o,
   output logic       waddr_ev_o,
   output logic       wdata_ev_o,
   output logic [7:0] byte_o,
   output logic       rd_take_o
);
   localparam int unsigned   CNT_W    = $clog2(BYTE_BITS + 2);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS);
   localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_BITS + 1);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (BUSY_CYCLES < 1) begin : g_bad_busy
         $error("BUSY_CYCLES must be at least 1");
      end
   endgenerate

   logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
   logic busy, wr_go;

   twi_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_samp (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_p(start_p), .stop_p(stop_p)
   );

   twi_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
      .clk(clk), .rst_n(rst_n), .go(wr_go), .busy(busy)
   );

   twi_state_t       st;
   logic [CNT_W-1:0] bitn;
   logic [7:0]       sh;
   logic             oe, rnw, mack, got_data;
   logic             dev_ev, waddr_ev, wdata_ev, rd_take;
   logic             dev_match;

   assign dev_match = (sh[7:4] == DEV_CODE) && (sh[3:1] == strap_i);
   assign wr_go     = stop_p & got_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE; bitn <= '0; sh <= '0; oe <= 1'b0;
         rnw <= 1'b0; mack <= 1'b0; got_data <= 1'b0;
         dev_ev <= 1'b0; waddr_ev <= 1'b0; wdata_ev <= 1'b0; rd_take <= 1'b0;
      end else begin
         dev_ev <= 1'b0; waddr_ev <= 1'b0; wdata_ev <= 1'b0; rd_take <= 1'b0;
         if (start_p) begin
            oe <= 1'b0; bitn <= '0; got_data <= 1'b0;
            st <= busy ? ST_IDLE : ST_DEV;
         end else if (stop_p) begin
            st <= ST_IDLE; oe <= 1'b0; got_data <= 1'b0;
         end else if (scl_rise) begin
            if (st != ST_IDLE) begin
               if (bitn < LAST_BIT) begin
                  bitn <= bitn + 1'b1;
                  if (st != ST_RDAT) sh <= {sh[6:0], sda_s};
               end else if (bitn == LAST_BIT) begin
                  bitn <= ACK_BIT;
                  mack <= ~sda_s;
               end
            end
         end else if (scl_fall) begin
            if (bitn == LAST_BIT) begin
               unique case (st)
                  ST_DEV: begin
                     if (dev_match) begin
                        oe <= 1'b1; rnw <= sh[0]; dev_ev <= 1'b1;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
                  ST_WADR: begin oe <= 1'b1; waddr_ev <= 1'b1; end
                  ST_WDAT: begin oe <= 1'b1; wdata_ev <= 1'b1; got_data <= 1'b1; end
                  ST_RDAT: oe <= 1'b0;
                  default: ;
               endcase
            end else if (bitn == ACK_BIT) begin
               bitn <= '0;
               unique case (st)
                  ST_DEV: begin
                     if (rnw) begin
                        st <= ST_RDAT; sh <= rd_data_i; oe <= ~rd_data_i[7]; rd_take <= 1'b1;
                     end else begin
                        st <= ST_WADR; oe <= 1'b0;
                     end
                  end
                  ST_WADR: begin st <= ST_WDAT; oe <= 1'b0; end
                  ST_WDAT: oe <= 1'b0;
                  ST_RDAT: begin
                     if (mack) begin
                        sh <= rd_data_i; oe <= ~rd_data_i[7]; rd_take <= 1'b1;
                     end else begin
                        st <= ST_IDLE; oe <= 1'b0;
                     end
                  end
                  default: ;
               endcase
            end else if (st == ST_RDAT && bitn != '0) begin
               sh <= {sh[6:0], 1'b0};
               oe <= ~sh[6];
            end
         end
      end
   end

   assign sda_oe_o   = oe;
   assign busy_o     = busy;
   assign dev_ev_o   = dev_ev;
   assign dev_rnw_o  = rnw;
   assign waddr_ev_o = waddr_ev;
   assign wdata_ev_o = wdata_ev;
   assign byte_o     = sh;
   assign rd_take_o  = rd_take;
endmodule

// File: rtl/twi_target_chk.sv
module twi_target_chk (
   input logic clk,
   input logic rst_n,
   input logic sda_oe,
   input logic busy,
   input logic wr_go,
   input logic scl_fall,
   input logic start_p,
   input logic stop_p,
   input logic dev_ev,
   input logic waddr_ev,
   input logic wdata_ev,
   input logic rd_take,
   input logic rnw
);
   // R5
   busy_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_go |=> busy);

   // R6
   busy_deaf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (!dev_ev && !sda_oe));

   // R10
   drive_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> $past(scl_fall));

   // R10
   release_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_oe) |-> $past(scl_fall || start_p || stop_p));

   // R4
   single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dev_ev, waddr_ev, wdata_ev, rd_take}));

   // R4
   write_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (waddr_ev || wdata_ev) |-> !rnw);

   // R8
   read_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_take |-> rnw);
endmodule

bind twi_target_engine twi_target_chk u_chk (
   .clk(clk), .rst_n(rst_n), .sda_oe(oe), .busy(busy), .wr_go(wr_go),
   .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p),
   .dev_ev(dev_ev), .waddr_ev(waddr_ev), .wdata_ev(wdata_ev),
   .rd_take(rd_take), .rnw(rnw)
);

// File: tb/sim_twi_target_engine.sv
module sim_twi_target_engine;
   localparam int BUSY = 600;
   localparam int Q    = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_c = 1'b1, sda_c = 1'b1;
   logic [2:0] strap = 3'b101;
   logic [7:0] rd_data;
   logic sda_oe, busy, dev_ev, dev_rnw, waddr_ev, wdata_ev, rd_take;
   logic [7:0] byte_v;
   wire  sda_line = sda_c & ~sda_oe;

   always #10 clk = ~clk;

   twi_target_engine #(.DEV_CODE(4'b1010), .BUSY_CYCLES(BUSY), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_c), .sda_i(sda_line), .strap_i(strap),
      .rd_data_i(rd_data), .sda_oe_o(sda_oe), .busy_o(busy), .dev_ev_o(dev_ev),
      .dev_rnw_o(dev_rnw), .waddr_ev_o(waddr_ev), .wdata_ev_o(wdata_ev),
      .byte_o(byte_v), .rd_take_o(rd_take)
   );

   int n_chk = 0, n_bad = 0;
   int dev_cnt = 0, waddr_cnt = 0, wdata_cnt = 0, rd_cnt = 0;
   int busy_run = 0, busy_last = 0;
   logic [7:0] last_waddr = 8'h00;
   logic [7:0] wlog [4];

   assign rd_data = 8'h30 + 8'(rd_cnt);

   always @(negedge clk) begin
      if (dev_ev)   dev_cnt <= dev_cnt + 1;
      if (waddr_ev) begin waddr_cnt <= waddr_cnt + 1; last_waddr <= byte_v; end
      if (wdata_ev) begin wlog[wdata_cnt % 4] <= byte_v; wdata_cnt <= wdata_cnt + 1; end
      if (rd_take)  rd_cnt <= rd_cnt + 1;
      if (busy) busy_run <= busy_run + 1;
      else begin
         if (busy_run != 0) busy_last <= busy_run;
         busy_run <= 0;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bstart();
      sda_c = 1'b1; tick(Q); scl_c = 1'b1; tick(Q); sda_c = 1'b0; tick(Q); scl_c = 1'b0; tick(Q);
   endtask

   task automatic bstop();
      sda_c = 1'b0; tick(Q); scl_c = 1'b1; tick(Q); sda_c = 1'b1; tick(Q);
   endtask

   task automatic bbit(input logic b, output logic r);
      logic late;
      sda_c = b; tick(Q); scl_c = 1'b1; tick(2); r = sda_line; tick(Q - 3);
      late = sda_line;
      // R10: line stable through the clock high phase
      chk(late === r, "R10", int'(late), int'(r));
      tick(1); scl_c = 1'b0; tick(Q);
   endtask

   task automatic wbyte(input logic [7:0] b, output logic ack);
      logic r;
      for (int i = 7; i >= 0; i--) bbit(b[i], r);
      bbit(1'b1, r);
      ack = ~r;
   endtask

   task automatic rbyte(input logic give_ack, output logic [7:0] d);
      logic r;
      for (int i = 7; i >= 0; i--) begin bbit(1'b1, r); d[i] = r; end
      bbit(~give_ack, r);
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 4000 && busy; i++) tick(1);
      tick(2);
   endtask

   // {address byte, expected acknowledge}
   localparam logic [8:0] VEC [6] = '{
      {8'hAA, 1'b1}, {8'hA8, 1'b0}, {8'h6A, 1'b0},
      {8'hAB, 1'b1}, {8'hBA, 1'b0}, {8'hAE, 1'b0}
   };

   initial begin
      logic ack;
      logic [7:0] d;
      int snap, dsnap, wsnap;
      tick(3);
      // R1: reset state
      chk(sda_oe == 1'b0, "R1", int'(sda_oe), 0);
      chk(busy == 1'b0, "R1", int'(busy), 0);
      rst_n = 1'b1;
      tick(10);
      chk(dev_cnt == 0 && waddr_cnt == 0 && wdata_cnt == 0, "R1", dev_cnt + waddr_cnt + wdata_cnt, 0);

      // R2 / R3: address decode table
      for (int i = 0; i < 6; i++) begin
         bstart();
         wbyte(VEC[i][8:1], ack);
         chk(ack == VEC[i][0], VEC[i][0] ? "R2" : "R3", int'(ack), int'(VEC[i][0]));
         if (ack && VEC[i][1]) rbyte(1'b0, d);
         bstop();
         tick(4);
      end
      chk(busy == 1'b0, "R5", int'(busy), 0);

      // R3: bytes after a mismatch are ignored
      wsnap = waddr_cnt;
      bstart(); wbyte(8'hA8, ack); wbyte(8'h55, ack);
      chk(ack == 1'b0, "R3", int'(ack), 0);
      chk(waddr_cnt == wsnap, "R3", waddr_cnt, wsnap);
      bstop(); tick(4);

      // R4 / R5 / R6: page write, then poll while busy
      dsnap = dev_cnt; wsnap = wdata_cnt;
      bstart(); wbyte(8'hAA, ack); wbyte(8'h10, ack);
      chk(ack == 1'b1 && last_waddr == 8'h10, "R4", int'(last_waddr), 8'h10);
      wbyte(8'h11, ack); wbyte(8'h22, ack); wbyte(8'hC3, ack);
      chk(ack == 1'b1, "R4", int'(ack), 1);
      chk(wdata_cnt == wsnap + 3, "R4", wdata_cnt, wsnap + 3);
      chk(wlog[wsnap % 4] == 8'h11 && wlog[(wsnap + 2) % 4] == 8'hC3, "R4",
          int'(wlog[(wsnap + 2) % 4]), 8'hC3);
      bstop();
      chk(busy == 1'b1, "R5", int'(busy), 1);
      dsnap = dev_cnt;
      bstart(); wbyte(8'hAA, ack);
      chk(ack == 1'b0, "R6", int'(ack), 0);
      chk(dev_cnt == dsnap, "R6", dev_cnt, dsnap);
      bstop();
      wait_idle();
      chk(busy_last == BUSY, "R5", busy_last, BUSY);
      bstart(); wbyte(8'hAA, ack);
      chk(ack == 1'b1, "R6", int'(ack), 1);
      bstop(); tick(20);
      chk(busy == 1'b0, "R5", int'(busy), 0);

      // R7: random read via dummy write
      bstart(); wbyte(8'hAA, ack); wbyte(8'h42, ack);
      chk(last_waddr == 8'h42, "R7", int'(last_waddr), 8'h42);
      snap = rd_cnt;
      bstart(); wbyte(8'hAB, ack);
      chk(ack == 1'b1, "R7", int'(ack), 1);
      rbyte(1'b0, d);
      chk(d == 8'(8'h30 + snap), "R7", int'(d), 8'h30 + snap);
      bstop(); tick(20);
      chk(busy == 1'b0, "R5", int'(busy), 0);

      // R8: sequential read, ends on controller non-acknowledge
      snap = rd_cnt;
      bstart(); wbyte(8'hAB, ack);
      for (int k = 0; k < 3; k++) begin
         rbyte(k != 2, d);
         chk(d == 8'(8'h30 + snap + k), "R8", int'(d), 8'h30 + snap + k);
      end
      chk(sda_oe == 1'b0, "R8", int'(sda_oe), 0);
      chk(rd_cnt == snap + 3, "R8", rd_cnt, snap + 3);
      bstop(); tick(4);

      // R9: start in the middle of a data byte
      wsnap = wdata_cnt;
      bstart(); wbyte(8'hAA, ack); wbyte(8'h20, ack);
      for (int i = 0; i < 4; i++) begin logic r; bbit(1'b0, r); end
      bstart(); wbyte(8'hAA, ack);
      chk(ack == 1'b1, "R9", int'(ack), 1);
      chk(wdata_cnt == wsnap, "R9", wdata_cnt, wsnap);
      bstop(); tick(20);
      chk(busy == 1'b0, "R9", int'(busy), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule